// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a bank of 2-bit saturating counters arranged as sets. A few bits of the branch address pick a set. A short shift register of recent global outcomes picks one counter inside that set. The outcomes in that register come from any branch, not only the one being looked up. This lets the guess for one branch depend on how the branches just before it went.

The block has two independent sides. The lookup side is purely combinational: a fetch stage presents a branch address and reads a taken/not-taken guess in the same cycle. The update side is used when a branch resolves. It takes the branch address and the real outcome, trains the single counter picked by the history as it stood before this branch, and then shifts the outcome into the history. There is no tag, so branches whose index bits match share a set. The number of sets, the history length and the address width are parameters. A history length of zero turns the block into a plain address-indexed counter table.

Top module: `bp_corr_predictor`

## Requirements
- R1: The lookup output is 1 (taken) when the selected counter holds 2'b10 or 2'b11, and 0 when it holds 2'b00 or 2'b01. The output is valid in the same cycle as the lookup address.
- R2: After reset every counter holds 2'b01 and the history is all zeros, so every lookup predicts not taken.
- R3: The set is chosen by address bits [SET_W+1:2], which are bits [5:2] with the default of 16 sets. Bits [1:0] and all bits above the index have no effect, so addresses with equal index bits share one set.
- R4: The history holds the outcomes of the last HIST_W updates (1 = taken), with the newest in bit 0. Within a set it selects the counter whose number equals the history value.
- R5: An update with outcome taken raises the selected counter by one, saturating at 2'b11. An update with outcome not taken lowers it by one, saturating at 2'b00.
- R6: An update changes only the counter at the updated address's set and the history value held before that update. All other counters keep their values.
- R7: The outcome is shifted into the history in the same clock edge as the counter write. The counter chosen for that write uses the history from before the shift.
- R8: A counter at 2'b11 or 2'b00 needs two updates against its direction in a row before its prediction flips.
- R9: With up_valid low, neither the counters nor the history change, whatever up_pc and up_taken carry.
- R10: With HIST_W = 0 each set holds one counter, and the block behaves as a counter table indexed only by the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Branch address to predict |
| lk_taken | output | 1 | Prediction for lk_pc, 1 = taken |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench drives the default predictor and a history-free copy together. Each cycle it compares both against a behavioural model that keeps a plain array of counters and an integer history.

The sequences target these corner cases:
- Training with the history after the shift would show up as the wrong counter moving once history and address vary.
- Counters that wrap instead of saturating would flip predictions after long runs in one direction.
- A single misprediction flipping a strong counter would break the hysteresis sequence.
- Decoding address bits [1:0] or the upper bits would break the aliasing case.
- Letting an update through while up_valid is low would shift the history, and every later prediction would differ.

// File: rtl/bp_pkg.sv
package bp_pkg;

   localparam int CTR_W = 2;

   typedef logic [CTR_W-1:0] ctr_t;

   // Weakly not-taken starting value for every counter.
   localparam ctr_t CTR_RESET = 2'b01;

   // Saturating step towards the resolved direction.
   function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
      ctr_t nxt;
      if (taken) nxt = (cur == 2'b11) ? cur : cur + 2'b01;
      else       nxt = (cur == 2'b00) ? cur : cur - 2'b01;
      return nxt;
   endfunction

   // Upper bit of a counter carries the direction.
   function automatic logic ctr_says_taken(input ctr_t cur);
      return cur[CTR_W-1];
   endfunction

endpackage

// File: rtl/bp_hist_reg.sv
module bp_hist_reg #(
   parameter int HIST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [HIST_W-1:0] hist_o
);

   logic [HIST_W-1:0] hist_q;

   generate
      if (HIST_W == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        hist_q <= '0;
            else if (shift_en) hist_q <= bit_in;
         end
      end else begin : g_multi
         // Newest outcome enters at bit 0; oldest falls off the top.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        hist_q <= '0;
            else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], bit_in};
         end
      end
   endgenerate

   assign hist_o = hist_q;

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
   import bp_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [IDX_W-1:0]           rd_idx,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic                       wr_taken,
   output ctr_t                       rd_ctr,
   output logic [(CTR_W<<IDX_W)-1:0]  cells_o
);

   localparam int NENT   = 1 << IDX_W;
   localparam int FLAT_W = NENT * CTR_W;

   logic [FLAT_W-1:0] cells_q;
   ctr_t              wr_old;

   assign rd_ctr = cells_q[rd_idx*CTR_W +: CTR_W];
   assign wr_old = cells_q[wr_idx*CTR_W +: CTR_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cells_q <= {NENT{CTR_RESET}};
      end else if (wr_en) begin
         cells_q[wr_idx*CTR_W +: CTR_W] <= ctr_step(wr_old, wr_taken);
      end
   end

   assign cells_o = cells_q;

endmodule

// File: rtl/bp_corr_predictor.sv
module bp_corr_predictor
   import bp_pkg::*;
#(
   parameter int PC_W    = 32,
   parameter int ALIGN_W = 2,
   parameter int SET_W   = 4,
   parameter int HIST_W  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_taken,
   input  logic            up_valid,
   input  logic [PC_W-1:0] up_pc,
   input  logic            up_taken
);

   localparam int NSETS = 1 << SET_W;
   localparam int NWAYS = 1 << HIST_W;
   localparam int NENT  = NSETS * NWAYS;
   localparam int IDX_W = SET_W + HIST_W;
   localparam int HSW   = (HIST_W > 0) ? HIST_W : 1;
   localparam int TOP_B = ALIGN_W + SET_W;

   // Elaboration-time parameter checks.
   generate
      if (SET_W < 1 || SET_W > 10) begin : g_bad_set
         $error("bp_corr_predictor: SET_W must lie in 1..10");
      end
      if (HIST_W < 0 || HIST_W > 8) begin : g_bad_hist
         $error("bp_corr_predictor: HIST_W must lie in 0..8");
      end
      if (ALIGN_W < 1) begin : g_bad_align
         $error("bp_corr_predictor: ALIGN_W must be at least 1");
      end
      if (PC_W <= TOP_B) begin : g_bad_pc
         $error("bp_corr_predictor: PC_W must exceed ALIGN_W + SET_W");
      end
   endgenerate

   logic [SET_W-1:0] lk_set;
   logic [SET_W-1:0] up_set;
   logic [HSW-1:0]   hist_q;
   logic [IDX_W-1:0] lk_idx;
   logic [IDX_W-1:0] upd_idx;
   ctr_t             lk_ctr;
   logic [NENT*CTR_W-1:0] cells;

   assign lk_set = lk_pc[ALIGN_W +: SET_W];
   assign up_set = up_pc[ALIGN_W +: SET_W];

   // Alignment and high address bits take no part in the index.
   logic pc_bits_unused;
   assign pc_bits_unused = ^{lk_pc[PC_W-1:TOP_B], lk_pc[ALIGN_W-1:0],
                             up_pc[PC_W-1:TOP_B], up_pc[ALIGN_W-1:0]};

   generate
      if (HIST_W > 0) begin : g_corr
         bp_hist_reg #(.HIST_W(HIST_W)) u_hist (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (up_valid),
            .bit_in   (up_taken),
            .hist_o   (hist_q)
         );
         // Set number in the upper index bits, history picks the way.
         assign lk_idx  = {lk_set, hist_q};
         assign upd_idx = {up_set, hist_q};
      end else begin : g_plain
         assign hist_q  = '0;
         assign lk_idx  = lk_set;
         assign upd_idx = up_set;
      end
   endgenerate

   bp_ctr_table #(.IDX_W(IDX_W)) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (lk_idx),
      .wr_en    (up_valid),
      .wr_idx   (upd_idx),
      .wr_taken (up_taken),
      .rd_ctr   (lk_ctr),
      .cells_o  (cells)
   );

   assign lk_taken = ctr_says_taken(lk_ctr);

endmodule

// File: rtl/bp_corr_predictor_chk.sv
module bp_corr_predictor_chk #(
   parameter int PC_W   = 32,
   parameter int HIST_W = 2,
   parameter int HSW    = 2,
   parameter int NENT   = 64,
   parameter int IDX_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PC_W-1:0]   lk_pc,
   input logic              lk_taken,
   input logic              up_valid,
   input logic              up_taken,
   input logic [IDX_W-1:0]  upd_idx,
   input logic [HSW-1:0]    hist_q,
   input logic [NENT*2-1:0] cells
);

   logic [1:0]        cyc;
   logic              armed;
   logic [IDX_W-1:0]  last_idx;
   logic [1:0]        upd_cell;
   logic [1:0]        new_cell;
   logic [NENT*2-1:0] wmask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc      <= '0;
         last_idx <= '0;
      end else begin
         if (cyc != 2'd2) cyc <= cyc + 2'd1;
         last_idx <= upd_idx;
      end
   end

   assign armed    = (cyc != 2'd0);
   assign upd_cell = cells[upd_idx*2 +: 2];
   assign new_cell = cells[last_idx*2 +: 2];
   assign wmask    = {{(NENT*2-2){1'b0}}, 2'b11} << (upd_idx*2);

   p_reset_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd0) |-> (cells == {NENT{2'b01}} && hist_q == '0));

   p_idle_cells_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(up_valid)) |-> (cells == $past(cells)));

   p_idle_hist_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(up_valid)) |-> (hist_q == $past(hist_q)));

   p_idle_lookup_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(up_valid) && $stable(lk_pc)) |-> $stable(lk_taken));

   p_other_cells_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(up_valid)) |-> (((cells ^ $past(cells)) & ~$past(wmask)) == '0));

   p_taken_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(up_valid && up_taken && upd_cell != 2'b11))
      |-> (new_cell == $past(upd_cell) + 2'b01));

   p_taken_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(up_valid && up_taken && upd_cell == 2'b11))
      |-> (new_cell == 2'b11));

   p_fall_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(up_valid && !up_taken && upd_cell != 2'b00))
      |-> (new_cell == $past(upd_cell) - 2'b01));

   p_fall_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(up_valid && !up_taken && upd_cell == 2'b00))
      |-> (new_cell == 2'b00));

   generate
      if (HIST_W > 0) begin : g_hist_new
         p_hist_newest_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(up_valid)) |-> (hist_q[0] == $past(up_taken)));
      end
      if (HIST_W > 1) begin : g_hist_age
         p_hist_age_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(up_valid))
            |-> (hist_q[HSW-1:1] == $past(hist_q[HSW-2:0])));
      end
   endgenerate

endmodule

bind bp_corr_predictor bp_corr_predictor_chk #(
   .PC_W   (PC_W),
   .HIST_W (HIST_W),
   .HSW    (HSW),
   .NENT   (NENT),
   .IDX_W  (IDX_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lk_pc    (lk_pc),
   .lk_taken (lk_taken),
   .up_valid (up_valid),
   .up_taken (up_taken),
   .upd_idx  (upd_idx),
   .hist_q   (hist_q),
   .cells    (cells)
);

// File: tb/bp_corr_predictor_tb.sv
module bp_corr_predictor_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NSETS      = 16;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] lk_pc;
   logic        lk_taken;
   logic        lk_taken0;
   logic        up_valid;
   logic [31:0] up_pc;
   logic        up_taken;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   // Behavioural reference: plain integer arrays.
   int m_ctr [NSETS][4];
   int m_hist;
   int m0_ctr[NSETS];

   always #(CLK_PERIOD/2) clk = ~clk;

   bp_corr_predictor u_dut (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
      .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

   bp_corr_predictor #(.HIST_W(0)) u_dut0 (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken0),
      .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

   function automatic int set_of(input logic [31:0] pc);
      return int'(pc[5:2]);
   endfunction

   function automatic int stepc(input int c, input logic t);
      if (t) return (c < 3) ? c + 1 : 3;
      return (c > 0) ? c - 1 : 0;
   endfunction

   task automatic check(input logic act, input logic exp, input string req);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: prediction %0b expected %0b", req, act, exp);
      end
   endtask

   // One cycle: drive at the falling edge, compare, then advance the model.
   task automatic cycle(input logic [31:0] lpc, input logic uv,
                        input logic [31:0] upc, input logic ut, input string req);
      lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
      #1;
      check(lk_taken,  m_ctr[set_of(lpc)][m_hist] >= 2, req);
      check(lk_taken0, m0_ctr[set_of(lpc)] >= 2, {req, " R10"});
      @(posedge clk);
      if (uv) begin
         m_ctr[set_of(upc)][m_hist] = stepc(m_ctr[set_of(upc)][m_hist], ut);
         m0_ctr[set_of(upc)]        = stepc(m0_ctr[set_of(upc)], ut);
         m_hist = ((m_hist << 1) | int'(ut)) & 3;
      end
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, got hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int s = 0; s < NSETS; s++) begin
         m0_ctr[s] = 1;
         for (int h = 0; h < 4; h++) m_ctr[s][h] = 1;
      end
      m_hist = 0;
      rst_n = 1'b0; lk_pc = '0; up_valid = 1'b0; up_pc = '0; up_taken = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2: every set predicts not taken after reset.
      for (int s = 0; s < NSETS; s++)
         cycle(32'h8000_0000 | (s << 2), 1'b0, '0, 1'b0, "R2");

      // R5 R7: first taken update trains the way picked by history 00.
      cycle(32'h0000_000C, 1'b1, 32'h0000_000C, 1'b1, "R5");
      cycle(32'h0000_000C, 1'b0, '0, 1'b0, "R7");

      // R4 R8: a run of taken outcomes saturates way 11 of set 3.
      for (int k = 0; k < 6; k++)
         cycle(32'h0000_000C, 1'b1, 32'h0000_000C, 1'b1, "R4");
      // One miss, then restore history through another set.
      cycle(32'h0000_000C, 1'b1, 32'h0000_000C, 1'b0, "R8");
      cycle(32'h0000_000C, 1'b1, 32'h0000_0020, 1'b1, "R8");
      cycle(32'h0000_000C, 1'b1, 32'h0000_0020, 1'b1, "R8");
      cycle(32'h0000_000C, 1'b0, '0, 1'b0, "R8");

      // R9: idle cycles with live-looking update data change nothing.
      for (int k = 0; k < 8; k++)
         cycle(32'h0000_000C ^ (k << 6), 1'b0, 32'h0000_000C, k[0], "R9");

      // R3: upper and alignment bits alias into the same set.
      cycle(32'hFFFF_FF13, 1'b1, 32'h1234_0010, 1'b1, "R3");
      cycle(32'h0000_0011, 1'b1, 32'hABCD_0013, 1'b1, "R3");
      cycle(32'h7000_0012, 1'b1, 32'h0000_0012, 1'b1, "R3");
      cycle(32'h5555_5510, 1'b0, '0, 1'b0, "R3");

      // R5: long not-taken run drives counters to the floor.
      for (int k = 0; k < 6; k++)
         cycle(32'h0000_000C, 1'b1, 32'h0000_000C, 1'b0, "R5");
      cycle(32'h0000_000C, 1'b1, 32'h0000_000C, 1'b1, "R8");

      // R1 R6: mixed traffic across a few sets and histories.
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] a, b;
         logic        v, t;
         a = {$urandom_range(15, 0), 4'h0} ^ (($urandom_range(5, 0)) << 2);
         b = {$urandom_range(15, 0), 4'h0} ^ (($urandom_range(5, 0)) << 2)
             ^ 32'($urandom_range(3, 0));
         v = ($urandom_range(3, 0) != 0);
         t = ($urandom_range(4, 0) > 1);
         cycle(a, v, b, t, "R1 R6");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule